// File: doc/BRIEF.md
# Multiplexed Byte-Bus Memory Slave

This block is a small RAM that answers on an 8-bit bus where addresses and data share the same lines. Three active-low strobes (load-address, read, write) qualify each bus cycle. A 16-bit address arrives as two bytes on two load-address cycles, low byte first. After that the slave keeps a local pointer. The pointer moves up by one after every read or write, so a block of bytes can be streamed without sending a new address.

The slave runs on a fast system clock. It samples the bus clock phase `phi1` as an ordinary input and acts on its falling edge. That edge is when every device on the bus captures data. The slave answers only when the pointer lies inside a window set by `BASE` and `SIZE_LOG2`.

On the read side there is a data output and a drive enable. When the slave is not driving, the output reads as all ones, which is how a pre-charged, undriven bus looks. The drive is dropped one system clock after the phi1 falling edge. It stays off until all strobes have been released.

Top module: `bytebus_mem_slave`

## Requirements
- R1: A load-address cycle with the toggle expecting the low byte stores `bus_in` as the low byte. The next load-address cycle stores `bus_in` as the high byte, and the pointer becomes {high, low}. Both bytes are captured on the falling edge of `phi1`.
- R2: After reset the slave never drives until a high address byte has been loaded. A lone low byte does not change the pointer.
- R3: During a read cycle (`rd_n` low, `lma_n` high) with the pointer in [BASE, BASE+2^SIZE_LOG2), `bus_oe` is 1 and `bus_out` is the RAM byte at the pointer. With the pointer outside that window, `bus_oe` stays 0.
- R4: In a cycle where `lma_n` and `rd_n` are both low, the slave does not drive. It still takes `bus_in` as an address byte.
- R5: The pointer advances by one after each read or write cycle, whether or not the pointer was in the window.
- R6: A write cycle (`wr_n` low, `lma_n` high) stores `bus_in` into RAM at the pointer on the phi1 falling edge, but only when the pointer is in the window. Writes outside the window change no RAM byte.
- R7: A bus cycle with no strobe active changes neither the pointer nor the RAM.
- R8: `bus_oe` is 0 from the first clock after a phi1 falling edge. It stays 0 until every strobe has gone inactive.
- R9: Any read or write cycle sets the address byte toggle back to "expect low byte".
- R10: Synchronous reset (`rst` high) clears the pointer and the byte toggle, marks the address invalid, and deasserts `bus_oe`.
- R11: Whenever `bus_oe` is 0, `bus_out` is 8'hFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| phi1 | input | 1 | Bus clock phase 1, sampled |
| lma_n | input | 1 | Load-address strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bus_in | input | 8 | Byte present on the shared bus |
| bus_out | output | 8 | Byte driven by the slave, 8'hFF when idle |
| bus_oe | output | 1 | Slave drives the bus |

## Verification
The assertions assume that `phi1` and the strobes are synchronous to `clk` and never change within the same clock. They also assume that each strobe is held across the whole phi1 high phase, including the falling edge, and that every bus cycle ends with all strobes released. The bench builds every bus cycle from one task that follows this order. It asserts the strobes, raises phi1, samples, drops phi1, then releases the strobes. No pulse shape outside these assumptions is ever produced.

// File: rtl/bytebus_mem_slave.sv
module bytebus_mem_slave #(
  parameter logic [15:0] BASE      = 16'h8200,
  parameter int          SIZE_LOG2 = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       phi1,
  input  logic       lma_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [7:0] bus_in,
  output logic [7:0] bus_out,
  output logic       bus_oe
);
  localparam int          DEPTH = 1 << SIZE_LOG2;
  localparam logic [16:0] LIMIT = 17'(DEPTH);

  logic                 phi1_d, done, lo_pend, addr_valid, oe_q;
  logic [7:0]           lo_byte;
  logic [15:0]          ptr, off;
  logic [SIZE_LOG2-1:0] idx;
  logic [7:0]           mem [DEPTH];

  wire fall   = phi1_d & ~phi1;
  wire any    = ~lma_n | ~rd_n | ~wr_n;
  wire access = lma_n & (~rd_n | ~wr_n);
  assign off  = ptr - BASE;
  assign idx  = off[SIZE_LOG2-1:0];
  wire hit    = addr_valid & ({1'b0, off} < LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      phi1_d     <= 1'b0;
      done       <= 1'b0;
      lo_pend    <= 1'b0;
      addr_valid <= 1'b0;
      oe_q       <= 1'b0;
      lo_byte    <= 8'h00;
      ptr        <= 16'h0000;
    end else begin
      phi1_d <= phi1;
      oe_q   <= ~rd_n & lma_n & hit & ~done & ~fall;
      if (fall) begin
        done <= 1'b1;
        if (!lma_n) begin
          if (!lo_pend) begin
            lo_byte <= bus_in;
            lo_pend <= 1'b1;
          end else begin
            ptr        <= {bus_in, lo_byte};
            lo_pend    <= 1'b0;
            addr_valid <= 1'b1;
          end
        end else if (access) begin
          ptr     <= ptr + 16'd1;
          lo_pend <= 1'b0;
        end
      end else if (!any) begin
        done <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && fall && lma_n && !wr_n && hit)
      mem[idx] <= bus_in;
  end

  assign bus_oe  = oe_q;
  assign bus_out = oe_q ? mem[idx] : 8'hFF;

  a_r8_release_after_fall: assert property (@(posedge clk) disable iff (rst)
    fall |=> !bus_oe);
  a_r4_no_drive_on_lma: assert property (@(posedge clk) disable iff (rst)
    !lma_n |=> !bus_oe);
  a_r2_no_drive_before_addr: assert property (@(posedge clk) disable iff (rst)
    !addr_valid |-> !bus_oe);
  a_r5_step_on_access: assert property (@(posedge clk) disable iff (rst)
    (fall && lma_n && (!rd_n || !wr_n)) |=> ptr == $past(ptr) + 16'd1);
  a_r7_idle_keeps_ptr: assert property (@(posedge clk) disable iff (rst)
    (fall && !any) |=> $stable(ptr));
  a_r10_reset_state: assert property (@(posedge clk)
    rst |=> (!bus_oe && ptr == 16'h0000 && !lo_pend));
endmodule

// File: tb/test_bytebus_mem_slave.sv
module test_bytebus_mem_slave;
  localparam logic [15:0] BASE = 16'h8200;
  localparam int          SZ   = 64;

  logic clk = 0, rst = 1, phi1 = 0, lma_n = 1, rd_n = 1, wr_n = 1;
  logic [7:0] bus_in = 8'hFF, bus_out;
  logic bus_oe;
  int checks = 0, failures = 0;
  bit finished = 0;
  logic       s_oe, s_oe_after;
  logic [7:0] s_out;

  always #2.5 clk = ~clk;

  bytebus_mem_slave #(.BASE(BASE), .SIZE_LOG2(6)) i_bytebus_mem_slave (
    .clk(clk), .rst(rst), .phi1(phi1), .lma_n(lma_n), .rd_n(rd_n), .wr_n(wr_n),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe));

  function automatic logic [7:0] pat(logic [15:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic bit inwin(logic [15:0] a);
    return (a >= BASE) && (a < BASE + 16'(SZ));
  endfunction

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(logic l, logic r, logic w, logic [7:0] d);
    @(negedge clk);
    lma_n = ~l; rd_n = ~r; wr_n = ~w; bus_in = d;
    repeat (4) @(negedge clk);
    phi1 = 1;
    repeat (4) @(negedge clk);
    s_oe = bus_oe; s_out = bus_out;
    phi1 = 0;
    repeat (2) @(negedge clk);
    s_oe_after = bus_oe;
    lma_n = 1; rd_n = 1; wr_n = 1; bus_in = 8'hFF;
    repeat (2) @(negedge clk);
  endtask

  task automatic load(logic [15:0] a);
    cyc(1, 0, 0, a[7:0]);
    cyc(1, 0, 0, a[15:8]);
  endtask

  task automatic expect_read(string req, logic [15:0] a);
    cyc(0, 1, 0, 8'hFF);
    chk(req, {s_oe, s_out}, inwin(a) ? {1'b1, pat(a)} : 9'h0FF);
    chk("R8", {8'h00, s_oe_after}, 9'h000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", {bus_oe, bus_out}, 9'h0FF);
    rst = 0;
    // R2: no drive with no address, nor after a lone low byte
    cyc(0, 1, 0, 8'hFF);
    chk("R2", {s_oe, s_out}, 9'h0FF);
    cyc(1, 0, 0, 8'h00);
    cyc(0, 1, 0, 8'hFF);
    chk("R2", {s_oe, s_out}, 9'h0FF);
    // R6: write sweep from two below the window to two above
    load(BASE - 16'd2);
    for (int a = 32'(BASE) - 2; a < 32'(BASE) + SZ + 2; a++) begin
      cyc(0, 0, 1, pat(16'(a)));
      if (a % 16 == 0) chk("R6 no drive on write", {8'h00, s_oe}, 9'h000);
    end
    // R3 R5 R7 R11: read sweep with idle cycles mixed in
    load(BASE - 16'd1);
    for (int a = 32'(BASE) - 1; a < 32'(BASE) + SZ + 1; a++) begin
      if (a % 5 == 0) begin
        cyc(0, 0, 0, 8'h3C);
        chk("R7 idle", {s_oe, s_out}, 9'h0FF);
      end
      expect_read("R3 R5 R6 R11 sweep", 16'(a));
    end
    // R4: load-address together with a read served elsewhere
    cyc(1, 0, 0, 8'h10);
    cyc(1, 1, 0, 8'h82);
    chk("R4", {s_oe, s_out}, 9'h0FF);
    expect_read("R1 R4 address taken", 16'h8210);
    // R9: a read between load-address cycles resets the toggle
    cyc(1, 0, 0, 8'h05);
    expect_read("R9 read mid-load", 16'h8211);
    load(16'h8220);
    expect_read("R9 toggle reset", 16'h8220);
    // R1 R5: top of window then one past it
    load(16'h823F);
    expect_read("R1 top", 16'h823F);
    expect_read("R5 past end", 16'h8240);
    // R9 after a write; out-of-window write leaves window intact
    cyc(1, 0, 0, 8'h07);
    cyc(0, 0, 1, 8'hAA);
    load(16'h8200);
    expect_read("R6 R9 window start", 16'h8200);
    // R10: reset invalidates the address
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk);
    chk("R10", {bus_oe, bus_out}, 9'h0FF);
    rst = 0;
    cyc(0, 1, 0, 8'hFF);
    chk("R10 R2 after reset", {s_oe, s_out}, 9'h0FF);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule